// File: doc/BRIEF.md
# Per-Strip Hit Histogram Engine

This block keeps a running count of hits for every strip served by one readout channel. The channel covers six front-end chips, each with 128 strips, so 768 strips are in use. Each strip has its own 16-bit counter in a 1024-entry memory. The strip's counter sits at address `chip * 128 + strip`.

A hit arrives as a chip number and a strip number under a valid/ready handshake. Each hit with a legal chip number starts a three-cycle update: the counter is read, incremented and written back. Hits are held off with backpressure until the update is done. Counters stop at their all-ones value and do not wrap. Hits that name a chip above the last one are dropped, and a separate error counter counts them.

Before a scan, a single start pulse runs a clear pass that writes zero into every address, one per cycle. After the scan, the host reads the counters through a simple request port that answers one cycle later.

Top module: `strip_hist`

## Requirements
- R1: When synchronous reset is released, `busy` is 0, `hit_ready` is 1, `rd_valid` is 0 and `err_count` is 0.
- R2: A hit with chip c (0 to 5) and strip s (0 to 127) increments only the counter at address c*128+s. No other address changes.
- R3: Once a legal hit is accepted, `hit_ready` is 0 and `busy` is 1 for exactly the next three cycles. In the fourth cycle `hit_ready` is 1 again.
- R4: Hits to the same strip sent back to back, each waiting only for `hit_ready`, are all counted.
- R5: A counter that holds its all-ones value (0xFFFF at the default width) keeps that value on further hits.
- R6: A hit with chip number 6 or 7 is accepted without backpressure. It changes no counter and leaves `busy` at 0. It raises `err_count` by one in the following cycle.
- R7: A `clear_start` pulse while `busy` is 0 writes zero to addresses 0 to 1023, one per cycle. `busy` is high for exactly 1024 cycles, starting the cycle after the pulse. The pass also zeroes `err_count`. A `clear_start` that arrives while `busy` is 1 has no effect.
- R8: While a clear is running, `hit_ready` is 0 and no hit is counted.
- R9: A `rd_req` sampled while `busy` is 0 gives, in the next cycle, `rd_valid` = 1 and `rd_data` equal to the counter at `rd_addr`. A `rd_req` sampled while `busy` is 1 gives `rd_valid` = 0.
- R10: When `clear_start` and `hit_valid` are both high in an idle cycle, the clear wins. `hit_ready` is 0 in that cycle and the hit is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_start | input | 1 | One-cycle pulse that starts a clear pass |
| hit_valid | input | 1 | A hit is offered |
| hit_chip | input | 3 | Chip number of the hit |
| hit_strip | input | 7 | Strip number within the chip |
| hit_ready | output | 1 | The hit is taken on this edge when `hit_valid` is also high |
| busy | output | 1 | An update or a clear pass is in progress |
| rd_req | input | 1 | Host read request |
| rd_addr | input | 10 | Counter address to read |
| rd_valid | output | 1 | `rd_data` holds the answer to last cycle's request |
| rd_data | output | 16 | Counter value read |
| err_count | output | 16 | Saturating count of dropped hits with an illegal chip number |

## Verification
Hits are sent to both ends of the address map: chip 0 strip 0, chip 5 strip 127, and addresses in between. The neighbours of each hit are read back. This separates a correct address computation from one that swaps or offsets the chip and strip fields. Repeated back-to-back hits on one strip show whether a later read sees the write of the update before it. A long run on one strip shows the difference between saturating and wrapping. The bench builds the block with a narrow counter so that the limit is reached quickly. Hits with illegal chip numbers, hits held during a clear, and a hit offered together with a clear start each check that their hit is dropped. They also check the error count and the backpressure seen on `hit_ready`.

// File: rtl/strip_hist_pkg.sv
package strip_hist_pkg;

  // Phases of one counter update
  typedef enum logic [1:0] {
    UPD_IDLE  = 2'd0,
    UPD_FETCH = 2'd1,
    UPD_BUMP  = 2'd2,
    UPD_STORE = 2'd3
  } upd_state_e;

endpackage

// File: rtl/hist_ram.sv
module hist_ram #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= store[raddr];
  end

endmodule

// File: rtl/hist_clear_seq.sv
module hist_clear_seq #(
  parameter int DEPTH = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output logic              active,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      addr   <= '0;
    end else if (!active) begin
      if (go) begin
        active <= 1'b1;
        addr   <= '0;
      end
    end else if (addr == LAST) begin
      active <= 1'b0;
      addr   <= '0;
    end else begin
      addr <= addr + 1'b1;
    end
  end

endmodule

// File: rtl/hist_upd_ctrl.sv
module hist_upd_ctrl
  import strip_hist_pkg::*;
#(
  parameter int CHIPS  = 6,
  parameter int STRIPS = 128,
  parameter int DEPTH  = 1024,
  parameter int CNT_W  = 16,
  parameter int ERR_W  = 16,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int CHIP_W  = $clog2(CHIPS),
  localparam int STRIP_W = $clog2(STRIPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_en,
  input  logic               err_clr,
  input  logic               hit_valid,
  input  logic [CHIP_W-1:0]  hit_chip,
  input  logic [STRIP_W-1:0] hit_strip,
  output logic               hit_ready,
  output logic               upd_busy,
  output logic               fetching,
  output logic [ADDR_W-1:0]  upd_addr,
  input  logic [CNT_W-1:0]   mem_rdata,
  output logic               wr_en,
  output logic [CNT_W-1:0]   wr_data,
  output logic [ERR_W-1:0]   err_count
);

  upd_state_e       state;
  logic             take;
  logic             chip_ok;
  logic [ADDR_W-1:0] hit_addr;
  logic [CNT_W-1:0] bumped;

  assign hit_ready = (state == UPD_IDLE) && take_en;
  assign take      = hit_valid && hit_ready;
  assign chip_ok   = {1'b0, hit_chip} < (CHIP_W + 1)'(CHIPS);
  assign hit_addr  = ADDR_W'(hit_chip) * ADDR_W'(STRIPS) + ADDR_W'(hit_strip);
  assign bumped    = (mem_rdata == '1) ? mem_rdata : mem_rdata + 1'b1;

  assign upd_busy = (state != UPD_IDLE);
  assign fetching = (state == UPD_FETCH);
  assign wr_en    = (state == UPD_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= UPD_IDLE;
      upd_addr <= '0;
      wr_data  <= '0;
    end else begin
      case (state)
        UPD_IDLE: begin
          if (take && chip_ok) begin
            upd_addr <= hit_addr;
            state    <= UPD_FETCH;
          end
        end
        UPD_FETCH: state <= UPD_BUMP;
        UPD_BUMP: begin
          wr_data <= bumped;
          state   <= UPD_STORE;
        end
        default: state <= UPD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || err_clr) begin
      err_count <= '0;
    end else if (take && !chip_ok && (err_count != '1)) begin
      err_count <= err_count + 1'b1;
    end
  end

endmodule

// File: rtl/strip_hist.sv
module strip_hist #(
  parameter int CHIPS  = 6,
  parameter int STRIPS = 128,
  parameter int DEPTH  = 1024,
  parameter int CNT_W  = 16,
  parameter int ERR_W  = 16,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int CHIP_W  = $clog2(CHIPS),
  localparam int STRIP_W = $clog2(STRIPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear_start,
  input  logic               hit_valid,
  input  logic [CHIP_W-1:0]  hit_chip,
  input  logic [STRIP_W-1:0] hit_strip,
  output logic               hit_ready,
  output logic               busy,
  input  logic               rd_req,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_valid,
  output logic [CNT_W-1:0]   rd_data,
  output logic [ERR_W-1:0]   err_count
);

  logic              clr_active;
  logic [ADDR_W-1:0] clr_addr;
  logic              clr_go;
  logic              upd_busy;
  logic              fetching;
  logic [ADDR_W-1:0] upd_addr;
  logic              upd_we;
  logic [CNT_W-1:0]  upd_wdata;
  logic [CNT_W-1:0]  mem_rdata;
  logic [ADDR_W-1:0] mem_raddr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [CNT_W-1:0]  mem_wdata;

  assign busy   = upd_busy || clr_active;
  assign clr_go = clear_start && !busy;

  hist_clear_seq #(.DEPTH(DEPTH)) u_clear (
    .clk    (clk),
    .rst    (rst),
    .go     (clr_go),
    .active (clr_active),
    .addr   (clr_addr)
  );

  hist_upd_ctrl #(
    .CHIPS(CHIPS), .STRIPS(STRIPS), .DEPTH(DEPTH), .CNT_W(CNT_W), .ERR_W(ERR_W)
  ) u_upd (
    .clk       (clk),
    .rst       (rst),
    .take_en   (!clr_active && !clear_start),
    .err_clr   (clr_go),
    .hit_valid (hit_valid),
    .hit_chip  (hit_chip),
    .hit_strip (hit_strip),
    .hit_ready (hit_ready),
    .upd_busy  (upd_busy),
    .fetching  (fetching),
    .upd_addr  (upd_addr),
    .mem_rdata (mem_rdata),
    .wr_en     (upd_we),
    .wr_data   (upd_wdata),
    .err_count (err_count)
  );

  assign mem_raddr = fetching ? upd_addr : rd_addr;
  assign mem_we    = clr_active || upd_we;
  assign mem_waddr = clr_active ? clr_addr : upd_addr;
  assign mem_wdata = clr_active ? '0 : upd_wdata;

  hist_ram #(.DEPTH(DEPTH), .DATA_W(CNT_W)) u_ram (
    .clk   (clk),
    .raddr (mem_raddr),
    .rdata (mem_rdata),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_req && !busy;
  end

  assign rd_data = mem_rdata;

endmodule

// File: rtl/strip_hist_chk.sv
module strip_hist_chk #(
  parameter int CHIPS  = 6,
  parameter int CHIP_W = 3,
  parameter int ERR_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              clear_start,
  input logic              hit_valid,
  input logic [CHIP_W-1:0] hit_chip,
  input logic              hit_ready,
  input logic              busy,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [ERR_W-1:0]  err_count
);

  logic good_take;
  logic bad_take;
  assign good_take = hit_valid && hit_ready && ({1'b0, hit_chip} <  (CHIP_W + 1)'(CHIPS));
  assign bad_take  = hit_valid && hit_ready && ({1'b0, hit_chip} >= (CHIP_W + 1)'(CHIPS));

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !rd_valid && err_count == '0));

  // R3
  update_window_chk: assert property (@(posedge clk) disable iff (rst)
    good_take |-> ##1 busy ##1 busy ##1 busy ##1 !busy);

  // R6
  bad_chip_chk: assert property (@(posedge clk) disable iff (rst)
    bad_take |=> (!busy && (err_count == ERR_W'($past(err_count) + 1'b1)
                            || $past(err_count) == '1)));

  // R7
  clear_begin_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_start && !busy) |=> (busy && !hit_ready));

  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !hit_ready);

  // R9
  read_reply_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(rd_req) && !$past(busy)));

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clear_start |-> !hit_ready);

endmodule

bind strip_hist strip_hist_chk #(.CHIPS(CHIPS), .CHIP_W(CHIP_W), .ERR_W(ERR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clear_start (clear_start),
  .hit_valid   (hit_valid),
  .hit_chip    (hit_chip),
  .hit_ready   (hit_ready),
  .busy        (busy),
  .rd_req      (rd_req),
  .rd_valid    (rd_valid),
  .err_count   (err_count)
);

// File: tb/strip_hist_test.sv
module strip_hist_test;

  localparam int TB_CNT_W = 4;
  localparam int DEPTH    = 1024;
  localparam int CMAX     = (1 << TB_CNT_W) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clear_start = 1'b0;
  logic       hit_valid = 1'b0;
  logic [2:0] hit_chip = '0;
  logic [6:0] hit_strip = '0;
  logic       hit_ready;
  logic       busy;
  logic       rd_req = 1'b0;
  logic [9:0] rd_addr = '0;
  logic       rd_valid;
  logic [TB_CNT_W-1:0] rd_data;
  logic [15:0] err_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_mem [DEPTH];
  int exp_err = 0;
  int    q_val[$];
  int    q_addr[$];
  string q_req[$];

  always #4 clk = ~clk;

  strip_hist #(.CNT_W(TB_CNT_W)) uut (
    .clk(clk), .rst(rst), .clear_start(clear_start),
    .hit_valid(hit_valid), .hit_chip(hit_chip), .hit_strip(hit_strip),
    .hit_ready(hit_ready), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_count(err_count)
  );

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected read results
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (q_val.size() == 0) begin
        check("R9", 1, 0, "unexpected rd_valid");
      end else begin
        automatic int    e = q_val.pop_front();
        automatic int    a = q_addr.pop_front();
        automatic string r = q_req.pop_front();
        check(r, int'(rd_data), e, $sformatf("read addr %0d", a));
      end
    end
  end

  task automatic host_read(int addr, string req);
    @(negedge clk);
    while (busy) @(negedge clk);
    rd_req = 1'b1;
    rd_addr = 10'(addr);
    q_val.push_back(exp_mem[addr]);
    q_addr.push_back(addr);
    q_req.push_back(req);
    @(posedge clk);
    #1 rd_req = 1'b0;
  endtask

  task automatic send_hit(int chip, int strip, bit timing);
    @(negedge clk);
    hit_valid = 1'b1;
    hit_chip  = 3'(chip);
    hit_strip = 7'(strip);
    while (!hit_ready) @(negedge clk);
    @(posedge clk);
    #1 hit_valid = 1'b0;
    if (chip < 6) begin
      if (exp_mem[chip*128+strip] < CMAX) exp_mem[chip*128+strip]++;
    end else if (exp_err < 65535) begin
      exp_err++;
    end
    if (timing) begin
      if (chip < 6) begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          check("R3", int'(hit_ready), 0, "ready during update");
          check("R3", int'(busy), 1, "busy during update");
        end
        @(negedge clk);
        check("R3", int'(hit_ready), 1, "ready after update");
      end else begin
        @(negedge clk);
        check("R6", int'(hit_ready), 1, "ready after dropped hit");
        check("R6", int'(busy), 0, "busy after dropped hit");
        check("R6", int'(err_count), exp_err, "err_count");
      end
    end
  endtask

  // mode: 0 plain, 1 with re-pulse, hit held and read probe, 2 hit offered with start
  task automatic do_clear(int mode);
    int n;
    @(negedge clk);
    while (busy) @(negedge clk);
    clear_start = 1'b1;
    if (mode == 2) begin
      hit_valid = 1'b1;
      hit_chip  = 3'd2;
      hit_strip = 7'd2;
      #1 check("R10", int'(hit_ready), 0, "ready with clear_start");
    end
    @(posedge clk);
    #1 clear_start = 1'b0;
    hit_valid = 1'b0;
    n = 0;
    forever begin
      @(negedge clk);
      if (!busy) break;
      n++;
      if (n == 1) check("R7", int'(hit_ready), 0, "ready at clear start");
      if (mode == 1) begin
        if (n == 2) begin hit_valid = 1'b1; hit_chip = 3'd1; hit_strip = 7'd1; end
        if (n >= 3 && n < 30) check("R8", int'(hit_ready), 0, "ready during clear");
        if (n == 30) hit_valid = 1'b0;
        if (n == 10) begin rd_req = 1'b1; rd_addr = 10'd5; end
        if (n == 11) begin
          rd_req = 1'b0;
          check("R9", int'(rd_valid), 0, "rd_valid for request while busy");
        end
        if (n == 500) clear_start = 1'b1;
        if (n == 501) clear_start = 1'b0;
      end
    end
    check("R7", n, DEPTH, "busy cycles of clear");
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 0;
    exp_err = 0;
    check("R7", int'(err_count), 0, "err_count after clear");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1", int'(busy), 0, "busy after reset");
    check("R1", int'(hit_ready), 1, "hit_ready after reset");
    check("R1", int'(rd_valid), 0, "rd_valid after reset");
    check("R1", int'(err_count), 0, "err_count after reset");

    // R7: full clear with a pulse ignored in the middle
    do_clear(1);
    host_read(0, "R7");
    host_read(1023, "R7");
    host_read(5, "R7");

    // R2 + R3: map corners and update timing
    send_hit(0, 0, 1);
    send_hit(5, 127, 1);
    send_hit(2, 5, 1);
    send_hit(3, 0, 1);
    host_read(0, "R2");
    host_read(1, "R2");
    host_read(767, "R2");
    host_read(766, "R2");
    host_read(261, "R2");
    host_read(260, "R2");
    host_read(262, "R2");
    host_read(384, "R2");
    host_read(127, "R2");

    // R4: back-to-back on one strip
    for (int i = 0; i < 5; i++) send_hit(1, 10, 0);
    host_read(138, "R4");

    // R5: saturation
    for (int i = 0; i < CMAX + 5; i++) send_hit(4, 3, 0);
    host_read(515, "R5");

    // R6: illegal chips
    send_hit(6, 3, 1);
    send_hit(7, 0, 1);
    host_read(771, "R6");
    host_read(896, "R6");
    host_read(0, "R6");

    // R8 + R9: hits and a read during clear
    do_clear(1);
    host_read(129, "R8");
    host_read(138, "R8");

    // R10: clear wins over a simultaneous hit
    send_hit(2, 2, 0);
    send_hit(6, 0, 0);
    do_clear(2);
    host_read(258, "R10");
    send_hit(2, 2, 0);
    host_read(258, "R9");

    repeat (5) @(negedge clk);
    check("R9", q_val.size(), 0, "outstanding reads");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule